// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Shared Prescaler

This block produces two pulse-width-modulated outputs, A and B, from one free-running counter that both channels share. The counter advances only on an increment enable. That enable comes from a prescaler, which can divide the system clock by one of seven powers of two or follow the rising edges of an external clock input. Each channel has its own duty value and its own period length. The period is either short, at 2^DUTY_W counter increments, or long, at 2^(SLOW_LSB+DUTY_W) increments. With the default parameters these are 256 and 32768.

Each output can be overridden with a static level. Output A can also carry the selected prescaler clock in place of its waveform, so the counter rate can be observed on a pin. Duty values are captured only at the channel's own period boundary. A duty change made in the middle of a period therefore never produces a truncated or stretched pulse.

Top module: `pwm_dual_gen`

## Requirements
- R1: For select codes 0 to 6, the counter advances once every 2^(code+1) system clocks.
- R2: Select code 7 makes the counter advance once for each rising edge of `ext_clk_i`. That input passes through a two-stage synchronizer first.
- R3: A channel whose period bit is 0 repeats every 2^DUTY_W increments and compares its duty against counter bits [DUTY_W-1:0]. With the bit at 1, it repeats every 2^(SLOW_LSB+DUTY_W) increments and compares against bits [SLOW_LSB+DUTY_W-1:SLOW_LSB].
- R4: Inside a period, the output is high from the boundary until the compared counter bits equal the duty value. A duty of d therefore gives d steps high, and a duty of 0 keeps the output low for the whole period.
- R5: A duty input takes effect only at the next period boundary of its own channel.
- R6: While `force_a_i` is 1, `pwm_a_o` equals `force_lvl_a_i` (0 gives low, 1 gives high), whatever the state of `clk_out_en_i`.
- R7: While `force_b_i` is 1, `pwm_b_o` equals `force_lvl_b_i` (0 gives low, 1 gives high), and the duty and modulation of B have no effect on the pin.
- R8: With `clk_out_en_i` at 1 and `force_a_i` at 0, `pwm_a_o` carries the selected prescaler clock, which is a square wave of period 2^(code+1) clocks. For code 7 it carries the synchronized external clock.
- R9: Reset clears the counter and the prescaler, and both outputs are low. They stay low until each channel reaches its first period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| pre_sel_i | input | 3 | Prescaler select: 0..6 select a divide tap, 7 selects the external clock |
| clk_out_en_i | input | 1 | Put the prescaler clock on output A |
| slow_a_i | input | 1 | Channel A long-period select |
| slow_b_i | input | 1 | Channel B long-period select |
| duty_a_i | input | DUTY_W | Channel A duty value |
| duty_b_i | input | DUTY_W | Channel B duty value |
| force_a_i | input | 1 | Override output A with a static level |
| force_b_i | input | 1 | Override output B with a static level |
| force_lvl_a_i | input | 1 | Level driven on A while overridden |
| force_lvl_b_i | input | 1 | Level driven on B while overridden |
| pwm_a_o | output | 1 | Channel A output |
| pwm_b_o | output | 1 | Channel B output |

## Verification
The bench builds the block with DUTY_W=4 and SLOW_LSB=2. This gives a short period of 16 increments and a long period of 64, so several full long periods of every mode fit in a few hundred clocks at the fastest tap. Because the comparison slices and the wrap detection keep the same structure under these values, duty 0, full-scale duty, mid-period duty changes and switches between tap and external clock can all be measured as whole-period high counts.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

  // Number of fixed divide taps; the next select code picks the external clock.
  localparam int unsigned TAP_COUNT = 7;
  localparam int unsigned SEL_W     = $clog2(TAP_COUNT + 1);

  // Per-channel static controls, grouped so the generate loop can index them.
  typedef struct packed {
    logic slow;
    logic force_en;
    logic force_lvl;
    logic clkout_en;
  } chan_ctl_t;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned TAPS  = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_i,
  output logic             tick_o,
  output logic             clk_o
);

  logic [TAPS-1:0] div_q;
  logic [TAPS-1:0] div_d;
  // [0] first sync flop, [1] synchronized level, [2] previous synchronized level
  logic [2:0]      ext_q;
  logic [2:0]      ext_d;
  logic [TAPS-1:0] tap_tick;
  logic            ext_rise;

  genvar k;
  generate
    for (k = 0; k < TAPS; k++) begin : g_tap
      assign tap_tick[k] = &div_q[k:0];
    end
  endgenerate

  assign ext_rise = ext_q[1] & ~ext_q[2];

  always_comb begin
    div_d = div_q + 1'b1;
    ext_d = {ext_q[1:0], ext_i};
  end

  always_comb begin
    tick_o = ext_rise;
    clk_o  = ext_q[1];
    for (int t = 0; t < TAPS; t++) begin
      if (sel_i == SEL_W'(t)) begin
        tick_o = tap_tick[t];
        clk_o  = div_q[t];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= div_d;
      ext_q <= ext_d;
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || !$stable(sel_i)));

  // R2
  ext_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i >= SEL_W'(TAPS) && tick_o) |-> $past(ext_q[0]));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_inc_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_inc_o = cnt_q + 1'b1;
    cnt_d     = tick_i ? cnt_inc_o : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned DUTY_W   = 8,
  parameter int unsigned SLOW_LSB = 7,
  parameter int unsigned CNT_W    = SLOW_LSB + DUTY_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [CNT_W-1:0]       cnt_inc_i,
  input  logic [DUTY_W-1:0]      duty_i,
  input  pwm_dual_pkg::chan_ctl_t ctl_i,
  input  logic                   pclk_i,
  output logic                   pin_o
);

  logic [DUTY_W-1:0] duty_act_q;
  logic [DUTY_W-1:0] duty_act_d;
  logic              pwm_q;
  logic              pwm_d;
  logic [DUTY_W-1:0] field_nxt;
  logic              wrap;
  logic              load;

  always_comb begin
    field_nxt = ctl_i.slow ? cnt_inc_i[SLOW_LSB +: DUTY_W] : cnt_inc_i[DUTY_W-1:0];
    wrap      = ctl_i.slow ? (&cnt_i) : (&cnt_i[DUTY_W-1:0]);
    load      = tick_i & wrap;
  end

  always_comb begin
    duty_act_d = duty_act_q;
    pwm_d      = pwm_q;
    if (load) begin
      duty_act_d = duty_i;
      pwm_d      = (duty_i != '0);
    end else if (tick_i && (field_nxt == duty_act_q)) begin
      pwm_d      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act_q <= '0;
      pwm_q      <= 1'b0;
    end else begin
      duty_act_q <= duty_act_d;
      pwm_q      <= pwm_d;
    end
  end

  always_comb begin
    if (ctl_i.force_en)       pin_o = ctl_i.force_lvl;
    else if (ctl_i.clkout_en) pin_o = pclk_i;
    else                      pin_o = pwm_q;
  end

  // R4
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act_q == '0) |-> !pwm_q);

  // R5
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_act_q));

  // R4
  rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> $past(load));

endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen #(
  parameter int unsigned DUTY_W   = 8,
  parameter int unsigned SLOW_LSB = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ext_clk_i,
  input  logic [pwm_dual_pkg::SEL_W-1:0]     pre_sel_i,
  input  logic                               clk_out_en_i,
  input  logic                               slow_a_i,
  input  logic                               slow_b_i,
  input  logic [DUTY_W-1:0]                  duty_a_i,
  input  logic [DUTY_W-1:0]                  duty_b_i,
  input  logic                               force_a_i,
  input  logic                               force_b_i,
  input  logic                               force_lvl_a_i,
  input  logic                               force_lvl_b_i,
  output logic                               pwm_a_o,
  output logic                               pwm_b_o
);

  import pwm_dual_pkg::*;

  localparam int unsigned CNT_W  = SLOW_LSB + DUTY_W;
  localparam int unsigned N_CHAN = 2;

  logic              rst_n_s;
  logic              tick;
  logic              pclk;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_inc;
  logic [DUTY_W-1:0] duty_arr [N_CHAN];
  chan_ctl_t         ctl_arr  [N_CHAN];
  logic [N_CHAN-1:0] pin;

  pwm_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  pwm_prescaler #(
    .TAPS  (TAP_COUNT),
    .SEL_W (SEL_W)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .sel_i  (pre_sel_i),
    .ext_i  (ext_clk_i),
    .tick_o (tick),
    .clk_o  (pclk)
  );

  pwm_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_i    (tick),
    .cnt_o     (cnt),
    .cnt_inc_o (cnt_inc)
  );

  always_comb begin
    duty_arr[0] = duty_a_i;
    duty_arr[1] = duty_b_i;
    ctl_arr[0]  = '{slow: slow_a_i, force_en: force_a_i,
                    force_lvl: force_lvl_a_i, clkout_en: clk_out_en_i};
    ctl_arr[1]  = '{slow: slow_b_i, force_en: force_b_i,
                    force_lvl: force_lvl_b_i, clkout_en: 1'b0};
  end

  genvar c;
  generate
    for (c = 0; c < N_CHAN; c++) begin : g_chan
      pwm_channel #(
        .DUTY_W   (DUTY_W),
        .SLOW_LSB (SLOW_LSB),
        .CNT_W    (CNT_W)
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n_s),
        .tick_i    (tick),
        .cnt_i     (cnt),
        .cnt_inc_i (cnt_inc),
        .duty_i    (duty_arr[c]),
        .ctl_i     (ctl_arr[c]),
        .pclk_i    (pclk),
        .pin_o     (pin[c])
      );
    end
  endgenerate

  assign pwm_a_o = pin[0];
  assign pwm_b_o = pin[1];

  // R9
  reset_low_chk: assert property (@(posedge clk)
    (!rst_n_s && !force_a_i && !clk_out_en_i) |-> !pwm_a_o);

endmodule

// File: tb/pwm_dual_gen_test.sv
`timescale 1ns/1ps
module pwm_dual_gen_test;

  localparam int DW = 4;
  localparam int SL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0;
  logic [2:0] sel = 3'd0;
  logic clk_out_en = 1'b0;
  logic slow_a = 1'b0, slow_b = 1'b0;
  logic [DW-1:0] duty_a = '0, duty_b = '0;
  logic force_a = 1'b0, force_b = 1'b0;
  logic lvl_a = 1'b0, lvl_b = 1'b0;
  logic pwm_a, pwm_b;
  logic ext_run = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_gen #(.DUTY_W(DW), .SLOW_LSB(SL)) uut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .pre_sel_i(sel),
    .clk_out_en_i(clk_out_en), .slow_a_i(slow_a), .slow_b_i(slow_b),
    .duty_a_i(duty_a), .duty_b_i(duty_b), .force_a_i(force_a),
    .force_b_i(force_b), .force_lvl_a_i(lvl_a), .force_lvl_b_i(lvl_b),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
  );

  // external clock: toggles every 3 system clocks while enabled
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (ext_run) ext_clk = ~ext_clk;
    end
  end

  // {slowA, dutyA, slowB, dutyB, expA, expB}; highs counted over 128 clocks at divide-by-2
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 4'd0,  1'b0, 4'd8,  8'd0,   8'd64 },
    {1'b0, 4'd5,  1'b1, 4'd15, 8'd40,  8'd120},
    {1'b0, 4'd15, 1'b1, 4'd1,  8'd120, 8'd8  },
    {1'b1, 4'd3,  1'b0, 4'd2,  8'd24,  8'd16 },
    {1'b1, 4'd0,  1'b1, 4'd7,  8'd0,   8'd56 },
    {1'b0, 4'd1,  1'b0, 4'd15, 8'd8,   8'd120}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n, output int ha, output int hb, output int ra);
    logic prev;
    ha = 0; hb = 0; ra = 0;
    prev = pwm_a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_a) ha++;
      if (pwm_b) hb++;
      if (pwm_a && !prev) ra++;
      prev = pwm_a;
    end
  endtask

  task automatic pulse_len_b(output int len);
    int guard;
    len = 0; guard = 0;
    while (!pwm_b && guard < 400) begin @(negedge clk); guard++; end
    while (pwm_b && guard < 400) begin len++; @(negedge clk); guard++; end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ha, hb, ra, len;
    duty_a = 4'd8; duty_b = 4'd8;
    repeat (4) @(negedge clk);
    // R9: outputs low during reset
    check("R9 reset A", int'(pwm_a), 0);
    check("R9 reset B", int'(pwm_b), 0);
    rst_n = 1'b1;
    // R9: first period boundary is 16 ticks (32 clocks) away, so both stay low
    measure(20, ha, hb, ra);
    check("R9 low before boundary A", ha, 0);
    check("R9 low before boundary B", hb, 0);

    // R3 R4: vector table
    foreach (VEC[i]) begin
      {slow_a, duty_a, slow_b, duty_b} = VEC[i][25:16];
      repeat (256) @(negedge clk);
      measure(128, ha, hb, ra);
      check($sformatf("R4 R3 vec%0d A", i), ha, int'(VEC[i][15:8]));
      check($sformatf("R4 R3 vec%0d B", i), hb, int'(VEC[i][7:0]));
    end

    // R1: divide-by-8 tap, fast duty 4: 128-clock period, 32 high
    slow_a = 1'b0; duty_a = 4'd4; sel = 3'd2;
    repeat (300) @(negedge clk);
    measure(128, ha, hb, ra);
    check("R1 div8", ha, 32);
    // R1: divide-by-4 tap, fast duty 3: 64-clock period, 12 high each
    duty_a = 4'd3; sel = 3'd1;
    repeat (300) @(negedge clk);
    measure(128, ha, hb, ra);
    check("R1 div4", ha, 24);

    // R2: external clock, one increment per 6 clocks, duty 2: 96-clock period, 12 high
    ext_run = 1'b1; duty_a = 4'd2; sel = 3'd7;
    repeat (300) @(negedge clk);
    measure(96, ha, hb, ra);
    check("R2 ext clock", ha, 12);
    // R8: synchronized external clock on pin A, 6-clock period
    clk_out_en = 1'b1;
    repeat (10) @(negedge clk);
    measure(96, ha, hb, ra);
    check("R8 ext clock out rises", ra, 16);
    clk_out_en = 1'b0; ext_run = 1'b0; sel = 3'd0;

    // R8: prescaler clock on pin A
    clk_out_en = 1'b1;
    repeat (4) @(negedge clk);
    measure(128, ha, hb, ra);
    check("R8 div2 out high", ha, 64);
    check("R8 div2 out rises", ra, 64);
    sel = 3'd2;
    repeat (16) @(negedge clk);
    measure(128, ha, hb, ra);
    check("R8 div8 out rises", ra, 16);
    sel = 3'd0;

    // R6: force A wins over clock output
    force_a = 1'b1; lvl_a = 1'b1;
    measure(64, ha, hb, ra);
    check("R6 force A high", ha, 64);
    lvl_a = 1'b0;
    measure(64, ha, hb, ra);
    check("R6 force A low", ha, 0);
    force_a = 1'b0; clk_out_en = 1'b0;

    // R7: force B, duty ignored
    force_b = 1'b1; lvl_b = 1'b0; duty_b = 4'd15; slow_b = 1'b0;
    repeat (64) @(negedge clk);
    measure(128, ha, hb, ra);
    check("R7 force B low", hb, 0);
    lvl_b = 1'b1; duty_b = 4'd0;
    repeat (64) @(negedge clk);
    measure(128, ha, hb, ra);
    check("R7 force B high", hb, 128);
    force_b = 1'b0;

    // R5: duty change mid-period applies only at next boundary
    duty_b = 4'd8;
    repeat (100) @(negedge clk);
    while (pwm_b) @(negedge clk);
    while (!pwm_b) @(negedge clk);
    repeat (6) @(negedge clk);
    duty_b = 4'd2;
    len = 6;
    while (pwm_b && len < 400) begin len++; @(negedge clk); end
    check("R5 current pulse kept", len, 16);
    pulse_len_b(len);
    check("R5 new duty next period", len, 4);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule